// File: doc/BRIEF.md
# Polling Two-Input Stream Merge Switch

This block is the merge element of a two-by-two switch stage in a multistage interconnect. It takes two valid/ready packet streams and combines them onto one valid/ready output, which can apply back-pressure. Each transfer on an input is a burst. The first word of a burst is a header, and its low bits hold the number of payload words that follow. The header is consumed inside the block. The payload words are passed to the output in order and unchanged.

The block never waits on an empty input. Each poll state looks at its input for one cycle and then moves on. The polling is deliberately lopsided. After a burst from the first input, polling starts again at the first input. After a burst from the second input, polling starts again at the second input. If the first input is empty and the second input is then also found empty, the merge is finished. The block raises a completion flag and accepts nothing more until a reset.

Top module: `pm_merge2`

## Requirements
- R1: While reset is held, and in the first cycle after reset is released, the block polls input 1. `in1_ready` is 1, `in2_ready` is 0, `out_valid` is 0 and `done` is 0.
- R2: When input 1 offers a word in the input-1 poll state, that word is taken as a header. The header is never presented on the output. The next N words from input 1 appear on `out_data` in arrival order, where N is the header's count field.
- R3: If input 1 is not valid in the input-1 poll state, the block polls input 2 in the very next cycle (`in2_ready`=1, `in1_ready`=0).
- R4: After the last payload word of an input-1 burst leaves, the block polls input 1 again. Back-to-back bursts on input 1 are merged with no input-2 poll between them.
- R5: After the last payload word of an input-2 burst leaves, the block polls input 2, not input 1. If input 2 is then empty, the block ends, even when input 1 is offering data. That input-1 data is left unconsumed.
- R6: If input 2 is found empty in its poll state, `done` goes to 1 and stays there until reset. While `done` is 1, both input readies and `out_valid` are 0.
- R7: While forwarding, the active input's ready equals `out_ready`, the inactive input's ready is 0, and `out_valid` follows the active input's valid. No word is lost or repeated under any `out_ready` pattern.
- R8: A header whose count field is 0 returns the block to the same poll state in the next cycle, and nothing is forwarded.
- R9: The count field is header bits [CNT_W-1:0] (bits [15:0] by default). Higher header bits have no effect on the burst length.
- R10: Asserting the synchronous active-low reset from any state, including the finished state, restarts the block in the input-1 poll state with the burst counter cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in1_valid | input | 1 | Input 1 word valid |
| in1_ready | output | 1 | Input 1 word accepted |
| in1_data | input | DATA_W | Input 1 header or payload word |
| in2_valid | input | 1 | Input 2 word valid |
| in2_ready | output | 1 | Input 2 word accepted |
| in2_data | input | DATA_W | Input 2 header or payload word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream can take a word |
| out_data | output | DATA_W | Forwarded payload word |
| done | output | 1 | Merge finished; held until reset |

## Verification
The hardest case to reach from the ports is R5. Input 1 has to be empty when it is polled, and then it has to become busy only while an input-2 burst is still being forwarded. The block should then end without ever looking back at input 1. The stimulus starts with input 1 empty and queues a burst on input 2 only. It watches the scoreboard drain, and after the first input-2 word has left it loads a full burst onto input 1. The bench then expects `done` and checks that all of that burst is still waiting on input 1. A second run mixes a zero-count header, headers with junk in their upper bits, and a stalling `out_ready` pattern. Any wrong count, an early exit, or a lost or repeated word shows up as a scoreboard mismatch.

// File: rtl/pm_pkg.sv
package pm_pkg;
   typedef enum logic [2:0] {
      PM_POLL_A = 3'd0,
      PM_FWD_A  = 3'd1,
      PM_POLL_B = 3'd2,
      PM_FWD_B  = 3'd3,
      PM_DONE   = 3'd4
   } pm_state_e;
endpackage

// File: rtl/pm_burst_counter.sv
module pm_burst_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             last
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt <= '0;
      else if (load)  cnt <= load_val;
      else if (dec)   cnt <= cnt - ONE;
   end

   assign last = (cnt == ONE);
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
   import pm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             a_valid,
   input  logic             b_valid,
   input  logic [CNT_W-1:0] hdr_a,
   input  logic [CNT_W-1:0] hdr_b,
   input  logic             out_ready,
   input  logic             last,
   output pm_state_e        state,
   output logic             load,
   output logic [CNT_W-1:0] load_val,
   output logic             dec
);
   pm_state_e nxt;

   always_comb begin
      nxt      = state;
      load     = 1'b0;
      load_val = '0;
      dec      = 1'b0;
      unique case (state)
         PM_POLL_A: begin
            if (a_valid) begin
               load     = 1'b1;
               load_val = hdr_a;
               nxt      = (hdr_a == '0) ? PM_POLL_A : PM_FWD_A;
            end else begin
               nxt = PM_POLL_B;
            end
         end
         PM_FWD_A: begin
            dec = a_valid && out_ready;
            if (dec && last) nxt = PM_POLL_A;
         end
         PM_POLL_B: begin
            if (b_valid) begin
               load     = 1'b1;
               load_val = hdr_b;
               nxt      = (hdr_b == '0) ? PM_POLL_B : PM_FWD_B;
            end else begin
               nxt = PM_DONE;
            end
         end
         PM_FWD_B: begin
            dec = b_valid && out_ready;
            if (dec && last) nxt = PM_POLL_B;
         end
         default: nxt = PM_DONE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= PM_POLL_A;
      else        state <= nxt;
   end
endmodule

// File: rtl/pm_route.sv
module pm_route
   import pm_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  pm_state_e         state,
   input  logic              a_valid,
   input  logic [DATA_W-1:0] a_data,
   input  logic              b_valid,
   input  logic [DATA_W-1:0] b_data,
   input  logic              out_ready,
   output logic              a_ready,
   output logic              b_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              done
);
   localparam int LANES = 2;

   logic [LANES-1:0]  lane_valid;
   logic [LANES-1:0]  lane_ready;
   logic [LANES-1:0]  lane_fwd;
   logic [DATA_W-1:0] lane_data [LANES];

   assign lane_valid   = {b_valid, a_valid};
   assign lane_data[0] = a_data;
   assign lane_data[1] = b_data;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam pm_state_e POLL_S = (g == 0) ? PM_POLL_A : PM_POLL_B;
      localparam pm_state_e FWD_S  = (g == 0) ? PM_FWD_A  : PM_FWD_B;
      assign lane_fwd[g]   = (state == FWD_S);
      assign lane_ready[g] = (state == POLL_S) || (lane_fwd[g] && out_ready);
   end

   always_comb begin
      out_data = '0;
      for (int i = 0; i < LANES; i++) begin
         out_data = out_data | (lane_data[i] & {DATA_W{lane_fwd[i]}});
      end
   end

   assign out_valid = |(lane_fwd & lane_valid);
   assign a_ready   = lane_ready[0];
   assign b_ready   = lane_ready[1];
   assign done      = (state == PM_DONE);
endmodule

// File: rtl/pm_merge2.sv
module pm_merge2
   import pm_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in1_valid,
   output logic              in1_ready,
   input  logic [DATA_W-1:0] in1_data,
   input  logic              in2_valid,
   output logic              in2_ready,
   input  logic [DATA_W-1:0] in2_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              done
);
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("pm_merge2: CNT_W must lie in 1..DATA_W");
   end

   pm_state_e        state;
   logic             load, dec, last;
   logic [CNT_W-1:0] load_val;

   pm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .a_valid(in1_valid), .b_valid(in2_valid),
      .hdr_a(in1_data[CNT_W-1:0]), .hdr_b(in2_data[CNT_W-1:0]),
      .out_ready(out_ready), .last(last),
      .state(state), .load(load), .load_val(load_val), .dec(dec)
   );

   pm_burst_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
      .dec(dec), .last(last)
   );

   pm_route #(.DATA_W(DATA_W)) u_route (
      .state(state),
      .a_valid(in1_valid), .a_data(in1_data),
      .b_valid(in2_valid), .b_data(in2_data),
      .out_ready(out_ready),
      .a_ready(in1_ready), .b_ready(in2_ready),
      .out_valid(out_valid), .out_data(out_data), .done(done)
   );
endmodule

// File: rtl/pm_merge2_chk.sv
module pm_merge2_chk
   import pm_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      in1_valid,
   input logic      in1_ready,
   input logic      in2_valid,
   input logic      in2_ready,
   input logic      out_valid,
   input logic      out_ready,
   input logic      done,
   input pm_state_e state
);
   a_r1_reset_poll: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (in1_ready && !in2_ready && !done && !out_valid));

   a_r3_empty_poll_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_POLL_A && !in1_valid) |=> (state == PM_POLL_B));

   a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (done && !in1_ready && !in2_ready && !out_valid));

   a_r6_done_on_empty_b: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_POLL_B && !in2_valid) |=> done);

   a_r7_single_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !(in1_ready && in2_ready));

   a_r7_ready_follows_out: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((in1_ready || in2_ready) == out_ready));

   a_r2_out_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (in1_valid || in2_valid));
endmodule

bind pm_merge2 pm_merge2_chk u_chk (
   .clk(clk), .rst_n(rst_n),
   .in1_valid(in1_valid), .in1_ready(in1_ready),
   .in2_valid(in2_valid), .in2_ready(in2_ready),
   .out_valid(out_valid), .out_ready(out_ready),
   .done(done), .state(state)
);

// File: tb/tb_pm_merge2.sv
module tb_pm_merge2;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in1_valid = 1'b0, in2_valid = 1'b0, out_ready = 1'b1;
   logic [DW-1:0] in1_data = '0, in2_data = '0;
   logic          in1_ready, in2_ready, out_valid, done;
   logic [DW-1:0] out_data;

   logic [DW-1:0] qa[$], qb[$], exp_q[$];
   int  vecs = 0, errs = 0, cyc = 0;
   bit  bp_mode = 1'b0;

   always #10 clk = ~clk;

   pm_merge2 #(.DATA_W(DW), .CNT_W(16)) dut (
      .clk(clk), .rst_n(rst_n),
      .in1_valid(in1_valid), .in1_ready(in1_ready), .in1_data(in1_data),
      .in2_valid(in2_valid), .in2_ready(in2_ready), .in2_data(in2_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .done(done)
   );

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      vecs++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // source, sink and scoreboard monitor
   initial begin
      logic fa, fb, fo;
      logic [DW-1:0] e;
      forever begin
         @(negedge clk);
         cyc++;
         fa = rst_n && in1_valid && in1_ready;
         fb = rst_n && in2_valid && in2_ready;
         fo = rst_n && out_valid && out_ready;
         if (rst_n && out_valid) begin
            chk(((in1_ready || in2_ready) == out_ready) && !(in1_ready && in2_ready),
                "R7 ready", {in1_ready, in2_ready}, {1'b0, out_ready});
         end
         if (fo) begin
            if (exp_q.size() == 0) chk(1'b0, "R2 extra word", out_data, '0);
            else begin
               e = exp_q.pop_front();
               chk(out_data == e, "R2 data", out_data, e);
            end
         end
         @(posedge clk);
         #1;
         if (fa) void'(qa.pop_front());
         if (fb) void'(qb.pop_front());
         in1_valid = (qa.size() > 0);
         in1_data  = (qa.size() > 0) ? qa[0] : '0;
         in2_valid = (qb.size() > 0);
         in2_data  = (qb.size() > 0) ? qb[0] : '0;
         out_ready = bp_mode ? ((cyc % 3) != 0) : 1'b1;
      end
   end

   task automatic reset_start();
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #3;
      qa.delete(); qb.delete(); exp_q.delete();
   endtask

   task automatic reset_end();
      repeat (2) @(posedge clk);
      #2 rst_n = 1'b1;
   endtask

   // driver: queue a burst on one input and its payload on the scoreboard
   task automatic burst(input bit port, input int n, input logic [15:0] upper,
                        input logic [DW-1:0] base, input bit expect_out);
      logic [DW-1:0] hdr;
      hdr = {upper, 16'(n)};
      if (port) qb.push_back(hdr); else qa.push_back(hdr);
      for (int i = 0; i < n; i++) begin
         if (port) qb.push_back(base + DW'(i)); else qa.push_back(base + DW'(i));
         if (expect_out) exp_q.push_back(base + DW'(i));
      end
   endtask

   task automatic wait_done();
      for (int i = 0; i < 400 && !(done && exp_q.size() == 0); i++) @(negedge clk);
   endtask

   initial begin
      // T1: reset state, empty polls, sticky completion
      reset_start();
      reset_end();
      @(negedge clk);
      chk(in1_ready && !in2_ready && !out_valid && !done, "R1 reset poll",
          {in1_ready, in2_ready, out_valid, done}, 4'b1000);
      @(negedge clk);
      chk(in2_ready && !in1_ready, "R3 move to poll 2", {in1_ready, in2_ready}, 2'b01);
      @(negedge clk);
      chk(done && !in1_ready && !in2_ready && !out_valid, "R6 done on empty",
          {done, in1_ready, in2_ready, out_valid}, 4'b1000);
      qa.push_back(32'h0000_0001);
      repeat (6) @(negedge clk);
      chk(done && !in1_ready && qa.size() == 1, "R6 done held", qa.size(), 1);

      // T2: reset out of done, mixed bursts, zero and junk headers, back-pressure
      reset_start();
      bp_mode = 1'b1;
      burst(1'b0, 3, 16'h0000, 32'hA000_0010, 1'b1);
      burst(1'b0, 0, 16'hABCD, 32'h0, 1'b1);          // R8 zero count, R9 junk
      burst(1'b0, 2, 16'h0000, 32'hA000_0020, 1'b1);  // R4 back-to-back on input 1
      burst(1'b1, 4, 16'hFFFF, 32'hB000_0030, 1'b1);  // R9 junk upper bits
      burst(1'b1, 0, 16'h0000, 32'h0, 1'b1);          // R8 zero count on input 2
      reset_end();
      wait_done();
      chk(done == 1'b1, "R10 R6 run completes", done, 1'b1);
      chk(exp_q.size() == 0, "R2 R9 all payload seen", exp_q.size(), 0);
      chk(qa.size() == 0 && qb.size() == 0, "R4 R8 headers consumed",
          qa.size() + qb.size(), 0);

      // T3: input 2 burst, input 1 loaded mid-burst is never revisited
      reset_start();
      bp_mode = 1'b0;
      burst(1'b1, 3, 16'h0000, 32'hC000_0040, 1'b1);
      reset_end();
      for (int i = 0; i < 50 && exp_q.size() > 2; i++) @(negedge clk);
      burst(1'b0, 2, 16'h0000, 32'hD000_0050, 1'b0);
      wait_done();
      chk(done == 1'b1, "R5 ends after input 2", done, 1'b1);
      chk(qa.size() == 3, "R5 input 1 untouched", qa.size(), 3);
      chk(exp_q.size() == 0, "R5 input 2 payload", exp_q.size(), 0);

      // T4: reset from done restarts a fresh input-1 burst
      reset_start();
      burst(1'b0, 1, 16'h0000, 32'hE000_0060, 1'b1);
      reset_end();
      wait_done();
      chk(done && exp_q.size() == 0, "R10 restart forwards", exp_q.size(), 0);

      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errs++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule